// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Walker

This block is the receive engine of one DMA channel. A client hands it a byte stream with an end-of-packet marker. The block writes those bytes into memory buffers described by a linked list of data descriptors. It reaches memory through a single 32-bit master port and uses that same port to fetch descriptors, write them back and update the channel context.

A walk begins with a start pulse that carries a descriptor address and a context address. The block fetches the descriptor, then accepts bytes into the buffer that the descriptor names, and advances a buffer pointer as it goes. A descriptor is closed when its buffer is full or when a packet ends. On close, the block writes the true end address and the updated flags back into the descriptor and raises raw interrupt bits. It then either follows the next link, or it marks the context as disabled and stops at the end of the list. While the channel is stopped at end of list, incoming bytes are refused.

Data descriptor layout, all words 32-bit little-endian:

| Offset | Content |
|--------|---------|
| +0 | link to the next descriptor |
| +4 | buffer start |
| +8 | flags: bit 0 last in list, bit 4 interrupt on close, bit 11 packet ended here |
| +12 | buffer end (exclusive) |

The context flags word sits at context address +4, and its bit 15 means disabled.

Top module: `s2m_desc_walker`

## Requirements
- R1: After reset, s_ready_o, mem_req_o, irq_o and eol_o are 0 and intr_raw_o is 0.
- R2: A start pulse in idle clears eol_o and fetches the descriptor words at +0, +4, +8 and +12. s_ready_o stays 0 whenever a memory transfer is in progress, whether it is a load, a write-back or a data word.
- R3: A byte accepted at buffer pointer P is written into lane P[1:0] of the word at P with the low two bits cleared. A partially filled word is written with byte enables only for the lanes it holds, so the neighbouring bytes in memory are left unchanged.
- R4: At most (end - start) bytes are accepted into a descriptor. The descriptor closes when the pointer reaches the end field.
- R5: A byte carrying end-of-packet closes the descriptor early. The written-back flags word has bit 11 set, and raw interrupt bit 3 is set.
- R6: On close, the word at +12 is rewritten with the actual fill point, which is the pointer after the last byte accepted.
- R7: On close, raw interrupt bits 0 and 1 are set if and only if flags bit 4 of the descriptor is set.
- R8: irq_o is the OR of (raw & intr_mask_i). It is recomputed only on a cycle in which the raw value changes, so a change of mask alone leaves irq_o unchanged. A 1 on an intr_ack_i bit clears that raw bit.
- R9: When the closed descriptor has flags bit 0 clear, the block loads the descriptor at its link address and continues filling from that descriptor's buffer start.
- R10: When the closed descriptor has flags bit 0 set, the block reads the context word at +4, sets bit 15 in it, writes it back, and then sets eol_o. While eol_o is 1, s_ready_o stays 0 and no stream data reaches memory.
- R11: A start pulse after end of list clears eol_o and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | begin a walk (taken only when idle) |
| desc_addr_i | input | AW | first data descriptor address |
| ctx_addr_i | input | AW | context descriptor address |
| s_valid_i | input | 1 | stream byte valid |
| s_data_i | input | 8 | stream byte |
| s_eop_i | input | 1 | this byte ends a packet |
| s_ready_o | output | 1 | stream byte accepted this cycle when valid |
| mem_req_o | output | 1 | memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | byte address (word aligned) |
| mem_wdata_o | output | 32 | write data |
| mem_be_o | output | 4 | write byte enables |
| mem_ack_i | input | 1 | request completes this cycle |
| mem_rdata_i | input | 32 | read data, valid with ack |
| intr_mask_i | input | 4 | interrupt mask |
| intr_ack_i | input | 4 | clear raw interrupt bits |
| intr_raw_o | output | 4 | raw interrupt bits |
| irq_o | output | 1 | masked interrupt request |
| eol_o | output | 1 | channel stopped at end of list |

## Verification
The hardest situation to reach from the ports is a stream that keeps offering bytes while one descriptor closes, is written back and the next one is loaded. That situation must give a stall with no lost or duplicated byte and a correct split between the two buffers. The bench holds s_valid_i high across a chained pair of descriptors whose boundary lands on a word edge, so the stall covers the flush, two write-backs and four loads. Unaligned starts and single-byte descriptors push the first and last partial words through the byte enables, and guard bytes on both sides of each buffer show that nothing else was touched.

// File: rtl/sm_walk_pkg.sv
package sm_walk_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int IRQ_W      = 4;

  // data descriptor word offsets (bytes)
  localparam int OFF_NEXT  = 0;
  localparam int OFF_BUF   = 4;
  localparam int OFF_FLAGS = 8;
  localparam int OFF_AFTER = 12;
  // context flags word offset
  localparam int CTX_OFF_FLAGS = 4;

  // flag bit positions
  localparam int FLG_EOL    = 0;
  localparam int FLG_INTR   = 4;
  localparam int FLG_IN_EOP = 11;
  localparam int CTX_DIS    = 15;

  // raw interrupt contributions
  localparam logic [IRQ_W-1:0] IRQ_DONE_SET = 4'b0011;
  localparam logic [IRQ_W-1:0] IRQ_EOP_SET  = 4'b1000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LD_NEXT,
    ST_LD_BUF,
    ST_LD_FLAGS,
    ST_LD_AFTER,
    ST_RUN,
    ST_FLUSH,
    ST_WB_FLAGS,
    ST_WB_AFTER,
    ST_CTX_RD,
    ST_CTX_WR
  } walk_st_e;
endpackage

// File: rtl/sm_byte_packer.sv
module sm_byte_packer #(
  parameter int BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear_i,
  input  logic                  load_i,
  input  logic [$clog2(BYTES)-1:0] lane_i,
  input  logic [7:0]            byte_i,
  output logic [8*BYTES-1:0]    word_o,
  output logic [BYTES-1:0]      be_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] byte_q;
    logic       en_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '0;
        en_q   <= 1'b0;
      end else if (clear_i) begin
        en_q <= 1'b0;
      end else if (load_i && (lane_i == g)) begin
        byte_q <= byte_i;
        en_q   <= 1'b1;
      end
    end
    assign word_o[g*8 +: 8] = byte_q;
    assign be_o[g]          = en_q;
  end

  // R3: a lane is filled at most once between flushes
  p_lane_once_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clear_i) |-> !be_o[lane_i]);
endmodule

// File: rtl/sm_intr_unit.sv
module sm_intr_unit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, raw_nxt;
  logic         irq_q;

  assign raw_nxt = (raw_q & ~ack_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else if (raw_nxt != raw_q) begin
      raw_q <= raw_nxt;
      irq_q <= |(raw_nxt & mask_i);
    end
  end

  assign raw_o = raw_q;
  assign irq_o = irq_q;

  // R8: the request line only moves together with the raw value
  p_irq_with_raw_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_o != $past(irq_o)) |-> (raw_o != $past(raw_o)));
  // R8: with nothing set or acknowledged the raw value holds
  p_raw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && ack_i == '0) |=> $stable(raw_o));
endmodule

// File: rtl/sm_walk_ctrl.sv
module sm_walk_ctrl
  import sm_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     desc_addr_i,
  input  logic [AW-1:0]     ctx_addr_i,
  input  logic              s_valid_i,
  input  logic              s_eop_i,
  output logic              s_ready_o,
  output logic              pk_load_o,
  output logic [LANE_W-1:0] pk_lane_o,
  output logic              pk_clear_o,
  input  logic [WORD_W-1:0] pk_word_i,
  input  logic [WORD_BYTES-1:0] pk_be_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [WORD_BYTES-1:0] mem_be_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [IRQ_W-1:0]  irq_set_o,
  output logic              eol_o
);
  localparam logic [AW-1:0] LANE_MASK = AW'(WORD_BYTES - 1);
  localparam logic [WORD_BYTES-1:0] ALL_BE = '1;

  walk_st_e          st_q;
  logic [AW-1:0]     d_addr_q, ctx_q, next_q, ptr_q, after_q, wr_addr_q;
  logic [WORD_W-1:0] flags_q, ctx_word_q;
  logic              closing_q, eol_q;

  logic          in_run, accept, last_byte, empty_close, close_now, word_full;
  logic [AW-1:0] ptr_inc;

  assign in_run      = (st_q == ST_RUN);
  assign s_ready_o   = in_run && (ptr_q != after_q);
  assign accept      = s_ready_o && s_valid_i;
  assign ptr_inc     = ptr_q + AW'(1);
  assign last_byte   = accept && ((ptr_inc == after_q) || s_eop_i);
  assign empty_close = in_run && (ptr_q == after_q);
  assign close_now   = last_byte || empty_close;
  assign word_full   = (ptr_q[LANE_W-1:0] == LANE_W'(WORD_BYTES - 1));

  assign pk_load_o  = accept;
  assign pk_lane_o  = ptr_q[LANE_W-1:0];
  assign pk_clear_o = (st_q == ST_FLUSH) && mem_ack_i;
  assign eol_o      = eol_q;

  always_comb begin
    irq_set_o = '0;
    if (close_now) begin
      if (flags_q[FLG_INTR]) irq_set_o = irq_set_o | IRQ_DONE_SET;
      if (last_byte && s_eop_i) irq_set_o = irq_set_o | IRQ_EOP_SET;
    end
  end

  // memory master request decode
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    case (st_q)
      ST_LD_NEXT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = d_addr_q + AW'(OFF_NEXT);
      end
      ST_LD_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = d_addr_q + AW'(OFF_BUF);
      end
      ST_LD_FLAGS: begin
        mem_req_o  = 1'b1;
        mem_addr_o = d_addr_q + AW'(OFF_FLAGS);
      end
      ST_LD_AFTER: begin
        mem_req_o  = 1'b1;
        mem_addr_o = d_addr_q + AW'(OFF_AFTER);
      end
      ST_FLUSH: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wr_addr_q;
        mem_wdata_o = pk_word_i;
        mem_be_o    = pk_be_i;
      end
      ST_WB_FLAGS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = d_addr_q + AW'(OFF_FLAGS);
        mem_wdata_o = flags_q;
        mem_be_o    = ALL_BE;
      end
      ST_WB_AFTER: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = d_addr_q + AW'(OFF_AFTER);
        mem_wdata_o = WORD_W'(ptr_q);
        mem_be_o    = ALL_BE;
      end
      ST_CTX_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ctx_q + AW'(CTX_OFF_FLAGS);
      end
      ST_CTX_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q + AW'(CTX_OFF_FLAGS);
        mem_wdata_o = ctx_word_q;
        mem_be_o    = ALL_BE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      d_addr_q   <= '0;
      ctx_q      <= '0;
      next_q     <= '0;
      ptr_q      <= '0;
      after_q    <= '0;
      wr_addr_q  <= '0;
      flags_q    <= '0;
      ctx_word_q <= '0;
      closing_q  <= 1'b0;
      eol_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          d_addr_q <= desc_addr_i;
          ctx_q    <= ctx_addr_i;
          eol_q    <= 1'b0;
          st_q     <= ST_LD_NEXT;
        end
        ST_LD_NEXT: if (mem_ack_i) begin
          next_q <= AW'(mem_rdata_i);
          st_q   <= ST_LD_BUF;
        end
        ST_LD_BUF: if (mem_ack_i) begin
          ptr_q <= AW'(mem_rdata_i);
          st_q  <= ST_LD_FLAGS;
        end
        ST_LD_FLAGS: if (mem_ack_i) begin
          flags_q <= mem_rdata_i;
          st_q    <= ST_LD_AFTER;
        end
        ST_LD_AFTER: if (mem_ack_i) begin
          after_q <= AW'(mem_rdata_i);
          st_q    <= ST_RUN;
        end
        ST_RUN: begin
          if (empty_close) begin
            closing_q <= 1'b1;
            st_q      <= ST_WB_FLAGS;
          end else if (accept) begin
            ptr_q     <= ptr_inc;
            wr_addr_q <= ptr_q & ~LANE_MASK;
            closing_q <= last_byte;
            if (last_byte && s_eop_i) flags_q[FLG_IN_EOP] <= 1'b1;
            if (last_byte || word_full) st_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (mem_ack_i) begin
          st_q <= closing_q ? ST_WB_FLAGS : ST_RUN;
        end
        ST_WB_FLAGS: if (mem_ack_i) st_q <= ST_WB_AFTER;
        ST_WB_AFTER: if (mem_ack_i) begin
          if (flags_q[FLG_EOL]) begin
            st_q <= ST_CTX_RD;
          end else begin
            d_addr_q <= next_q;
            st_q     <= ST_LD_NEXT;
          end
        end
        ST_CTX_RD: if (mem_ack_i) begin
          ctx_word_q <= mem_rdata_i | (WORD_W'(1) << CTX_DIS);
          st_q       <= ST_CTX_WR;
        end
        ST_CTX_WR: if (mem_ack_i) begin
          eol_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: stream is refused while stopped at end of list
  p_eol_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    eol_o |-> !s_ready_o);
  // R4: the byte that reaches the end field stops acceptance
  p_stop_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && (ptr_inc == after_q)) |=> !s_ready_o);
  // R5: packet end leads straight to a closing flush
  p_eop_close_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && s_eop_i) |=> (st_q == ST_FLUSH && closing_q));
  // R2: a pending request holds its address and direction
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R2: no stream acceptance during a memory transfer
  p_no_ready_in_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> !s_ready_o);
  // R3: every data flush carries at least one byte
  p_flush_bytes_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FLUSH) |-> (pk_be_i != '0));
endmodule

// File: rtl/s2m_desc_walker.sv
module s2m_desc_walker
  import sm_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     desc_addr_i,
  input  logic [AW-1:0]     ctx_addr_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_eop_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_be_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic [3:0]        intr_mask_i,
  input  logic [3:0]        intr_ack_i,
  output logic [3:0]        intr_raw_o,
  output logic              irq_o,
  output logic              eol_o
);
  logic                  pk_load, pk_clear;
  logic [LANE_W-1:0]     pk_lane;
  logic [WORD_W-1:0]     pk_word;
  logic [WORD_BYTES-1:0] pk_be;
  logic [IRQ_W-1:0]      irq_set;

  sm_walk_ctrl #(.AW(AW)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .desc_addr_i (desc_addr_i),
    .ctx_addr_i  (ctx_addr_i),
    .s_valid_i   (s_valid_i),
    .s_eop_i     (s_eop_i),
    .s_ready_o   (s_ready_o),
    .pk_load_o   (pk_load),
    .pk_lane_o   (pk_lane),
    .pk_clear_o  (pk_clear),
    .pk_word_i   (pk_word),
    .pk_be_i     (pk_be),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .irq_set_o   (irq_set),
    .eol_o       (eol_o)
  );

  sm_byte_packer #(.BYTES(WORD_BYTES)) pack_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (pk_clear),
    .load_i  (pk_load),
    .lane_i  (pk_lane),
    .byte_i  (s_data_i),
    .word_o  (pk_word),
    .be_o    (pk_be)
  );

  sm_intr_unit #(.W(IRQ_W)) intr_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (irq_set),
    .ack_i  (intr_ack_i),
    .mask_i (intr_mask_i),
    .raw_o  (intr_raw_o),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/s2m_desc_walker_tb_top.sv
`timescale 1ns/1ps
module s2m_desc_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] desc_addr = '0, ctx_addr = '0;
  logic        s_valid = 1'b0, s_eop = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [3:0]  intr_mask = 4'hF, intr_ack = 4'h0, intr_raw;
  logic        irq, eol;

  int checks = 0;
  int failures = 0;
  int overlap = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  s2m_desc_walker dut_i (
    .clk(clk), .rst(rst), .start_i(start), .desc_addr_i(desc_addr),
    .ctx_addr_i(ctx_addr), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_eop_i(s_eop), .s_ready_o(s_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .intr_mask_i(intr_mask), .intr_ack_i(intr_ack), .intr_raw_o(intr_raw),
    .irq_o(irq), .eol_o(eol)
  );

  // memory responder: 4 KB, ack one cycle after request
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
      end else begin
        mem_ack <= 1'b0;
      end
      if (mem_req && mem_ack && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  // R2 monitor: stream ready never overlaps a memory request
  always @(negedge clk) begin
    cycles++;
    if (!rst && s_ready && mem_req) overlap++;
  end

  function automatic logic [7:0] rd_byte(int a);
    return mem[a >> 2][(a % 4) * 8 +: 8];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_walk(logic [31:0] d, logic [31:0] c);
    desc_addr = d; ctx_addr = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, logic e);
    s_valid = 1'b1; s_data = d; s_eop = e;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_eop = 1'b0;
  endtask

  task automatic wait_eol();
    while (!eol) @(negedge clk);
  endtask

  task automatic put_desc(int d, logic [31:0] nx, logic [31:0] bf,
                          logic [31:0] fl, logic [31:0] af);
    mem[(d >> 2)]     = nx;
    mem[(d >> 2) + 1] = bf;
    mem[(d >> 2) + 2] = fl;
    mem[(d >> 2) + 3] = af;
  endtask

  task automatic ack_all();
    intr_ack = 4'hF;
    @(negedge clk);
    intr_ack = 4'h0;
  endtask

  typedef struct packed {
    logic [11:0] buf_a;
    logic [7:0]  len;
    logic [7:0]  nsend;
    logic        eop;
    logic        intr;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{12'h100, 8'd8,  8'd8, 1'b0, 1'b1},
    '{12'h121, 8'd6,  8'd6, 1'b0, 1'b0},
    '{12'h142, 8'd12, 8'd5, 1'b1, 1'b0},
    '{12'h163, 8'd1,  8'd1, 1'b1, 1'b1},
    '{12'h180, 8'd16, 8'd3, 1'b1, 1'b1}
  };

  localparam int DA = 'h400;
  localparam int DB = 'h410;
  localparam int CTX = 'h500;
  localparam logic [31:0] MD = 32'h00AB_0000;

  initial begin : watchdog
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 s_ready", 32'(s_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 raw", 32'(intr_raw), 0);
    chk("R1 eol", 32'(eol), 0);

    // table of single-descriptor walks
    for (int v = 0; v < NV; v++) begin
      vec_t c;
      int bf, n, endp;
      logic [31:0] fl, exp_raw, exp_fl;
      c = VECS[v];
      bf = int'(c.buf_a);
      n = int'(c.nsend);
      endp = bf + n;
      fl = MD | 32'h1 | (32'(c.intr) << 4);
      put_desc(DA, 32'h0, 32'(bf), fl, 32'(bf + int'(c.len)));
      mem[CTX >> 2] = 32'h0;
      mem[(CTX >> 2) + 1] = 32'h0000_0041;
      start_walk(32'(DA), 32'(CTX));
      chk("R2 ready low during load", 32'(s_ready), 0);
      chk("R11 eol cleared by start", 32'(eol), 0);
      for (int k = 0; k < n; k++)
        send_byte(8'(8'h30 + v * 16 + k), (k == n - 1) ? c.eop : 1'b0);
      wait_eol();
      begin
        int bad = 0;
        for (int k = 0; k < n; k++)
          if (rd_byte(bf + k) !== 8'(8'h30 + v * 16 + k)) bad++;
        chk("R3 data bytes little-endian", 32'(bad), 0);
      end
      chk("R3 guard byte before buffer", 32'(rd_byte(bf - 1)), 32'hEE);
      chk("R4 guard byte after fill", 32'(rd_byte(endp)), 32'hEE);
      exp_fl = fl | (c.eop ? 32'h800 : 32'h0);
      chk("R5 flags write-back", mem[(DA >> 2) + 2], exp_fl);
      chk("R6 end field = fill point", mem[(DA >> 2) + 3], 32'(endp));
      exp_raw = (c.intr ? 32'h3 : 32'h0) | (c.eop ? 32'h8 : 32'h0);
      chk("R7 R5 raw interrupt", 32'(intr_raw), exp_raw);
      chk("R8 irq with full mask", 32'(irq), 32'(exp_raw != 0));
      chk("R10 context disabled bit", mem[(CTX >> 2) + 1], 32'h0000_8041);
      chk("R10 eol set", 32'(eol), 1);
      ack_all();
      chk("R8 ack clears raw", 32'(intr_raw), 0);
      chk("R8 irq drops with raw", 32'(irq), 0);
    end

    // R4: more bytes offered than the buffer holds
    put_desc(DA, 32'h0, 32'h2C0, 32'h1, 32'h2C2);
    start_walk(32'(DA), 32'(CTX));
    send_byte(8'h11, 1'b0);
    send_byte(8'h22, 1'b0);
    s_valid = 1'b1; s_data = 8'h33;
    wait_eol();
    s_valid = 1'b0;
    chk("R4 third byte not stored", 32'(rd_byte('h2C2)), 32'hEE);
    chk("R4 end field", mem[(DA >> 2) + 3], 32'h2C2);
    ack_all();

    // R9: chained descriptors, stream held valid across the boundary
    put_desc(DA, 32'(DB), 32'h200, 32'h0, 32'h204);
    put_desc(DB, 32'h0, 32'h240, 32'h1, 32'h250);
    start_walk(32'(DA), 32'(CTX));
    for (int k = 0; k < 6; k++)
      send_byte(8'(8'hA0 + k), (k == 5) ? 1'b1 : 1'b0);
    wait_eol();
    chk("R9 first buffer word", mem['h200 >> 2], 32'hA3A2_A1A0);
    chk("R9 second buffer lanes", 32'(mem['h240 >> 2]), 32'hEEEE_A5A4);
    chk("R9 first end field", mem[(DA >> 2) + 3], 32'h204);
    chk("R9 second end field", mem[(DB >> 2) + 3], 32'h242);
    chk("R9 second flags with packet end", mem[(DB >> 2) + 2], 32'h801);
    chk("R9 first flags untouched", mem[(DA >> 2) + 2], 32'h0);
    chk("R9 raw after chain", 32'(intr_raw), 32'h8);
    ack_all();

    // R10: refusal while stopped
    begin
      int rdy = 0;
      int reqs = 0;
      s_valid = 1'b1; s_data = 8'h5A; s_eop = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (s_ready) rdy++;
        if (mem_req) reqs++;
      end
      s_valid = 1'b0; s_eop = 1'b0;
      chk("R10 ready held low", 32'(rdy), 0);
      chk("R10 no memory traffic", 32'(reqs), 0);
      chk("R10 memory after fill unchanged", 32'(rd_byte('h242)), 32'hEE);
      chk("R10 eol stays", 32'(eol), 1);
    end

    // R8: mask change alone does not move irq; R11 restart after eol
    intr_mask = 4'h0;
    put_desc(DA, 32'h0, 32'h300, 32'h11, 32'h302);
    start_walk(32'(DA), 32'(CTX));
    chk("R11 restart clears eol", 32'(eol), 0);
    send_byte(8'h61, 1'b0);
    send_byte(8'h62, 1'b0);
    wait_eol();
    chk("R7 raw with intr flag", 32'(intr_raw), 32'h3);
    chk("R8 masked irq low", 32'(irq), 0);
    intr_mask = 4'hF;
    repeat (3) @(negedge clk);
    chk("R8 mask alone no re-evaluation", 32'(irq), 0);
    intr_ack = 4'h1;
    @(negedge clk);
    intr_ack = 4'h0;
    chk("R8 partial ack raw", 32'(intr_raw), 32'h2);
    chk("R8 irq re-evaluated on raw change", 32'(irq), 1);
    ack_all();
    chk("R8 final ack", 32'(irq), 0);

    chk("R2 ready never during memory transfer", 32'(overlap), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule